// File: doc/BRIEF.md
# Stochastic Competitive-Learning Neuron Element

This block is one processing element of a linear neuron array in which every element listens to the same broadcast bus and takes the same command from a global controller each cycle. The element keeps a small register file holding its weight elements, its topological coordinates and scratch words. It builds a Manhattan distance by feeding local-minus-broadcast differences through a two-stage pipeline: a subtractor stage that registers the difference and its sign, then an accumulate stage that adds or subtracts that registered difference so that only magnitudes are summed.

During the winner search the controller broadcasts trial distances. Each enabled element reports on a wired-OR status output when its accumulated distance is below the trial value, and drops out when its distance is above it. The controller can roll the enable flag back to its value before the latest search step, or turn every element on again. For neighbourhood learning, an element saves its topological distance to the winner and compares it with a broadcast random threshold. A weight element is then stepped by one toward the training value when the per-element distance exceeds a second broadcast threshold. The steps saturate at the limits of the 10-bit signed range.

All data is 10-bit two's complement. Distance comparisons treat the accumulator and the bus as unsigned magnitudes.

Top module: `neuron_pe`

## Requirements
- R1: After reset the enable flag is 1, the accumulator is 0, the status output is low and every register-file word reads 0.
- R2: Command 1 (write), when enabled, stores bus_i into the word at addr_i, and rdata_o shows the new value after the clock edge.
- R3: Command 2 (difference), when enabled, registers operand minus bus_i (10-bit wrapped) and its bit 9 as the sign flag at the first edge. At the next edge the accumulator adds the registered difference if the sign flag is 0 and subtracts it if the sign flag is 1. Back-to-back difference commands each contribute.
- R4: With sel_acc_i high the operand of command 2 is the accumulator; with it low the operand is the word at addr_i.
- R5: Command 3 (clear accumulator) sets the accumulator to 0 at the next edge, cancels a pending accumulation, and acts even when the element is disabled.
- R6: During command 4 (search), status_o is high in the same cycle exactly when the element is enabled and the accumulator is below bus_i (unsigned). An enabled element whose accumulator is above bus_i clears its enable flag at the edge. An equal value keeps it enabled.
- R7: Command 4 saves the enable flag as it was before that command. Command 5 (restore) loads the enable flag from that saved value. Command 6 (re-enable) sets the enable flag to 1.
- R8: Command 7 copies the accumulator into the topological-distance register when enabled. Command 8 clears the enable flag when the element is enabled and that register is above bus_i (unsigned).
- R9: Command 9 (learn), when enabled and the magnitude of the registered difference exceeds bus_i (unsigned), steps the word at addr_i by +1 if the sign flag is 1 and by -1 if it is 0. Otherwise the word is left unchanged.
- R10: A learning step never wraps: +1 at 511 leaves 511, and -1 at -512 leaves -512.
- R11: While disabled, commands 1, 2, 4, 7, 8 and 9 change no stored word, accumulator, enable flag or topological-distance register, and status_o stays low. Commands 3, 5 and 6 still act.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_i | input | 4 | Command code from the controller |
| addr_i | input | 3 | Register-file word address |
| sel_acc_i | input | 1 | Use the accumulator instead of the addressed word as the subtractor operand |
| bus_i | input | 10 | Broadcast data, threshold or trial distance |
| status_o | output | 1 | Wired-OR search status contribution |
| en_o | output | 1 | Enable flag |
| acc_o | output | 10 | Accumulator value |
| rdata_o | output | 10 | Word at addr_i |

## Verification
The properties assume that the controller drives only the listed command codes and holds addr_i steady from a learn command into the following cycle when checking for wrap, and that the broadcast values follow the unsigned reading of distances. The stimulus table keeps weight and training values small enough that differences stay in range, except in the deliberate saturation cases. There, out-of-range differences are chosen so that the wrapped sign points at the limit being tested. Every command is issued with the enable flag both set and cleared, and the address stays fixed across each step whose result is read back.

// File: rtl/pe_pkg.sv
package pe_pkg;

  typedef enum logic [3:0] {
    PE_NOP      = 4'd0,
    PE_WRITE    = 4'd1,
    PE_DIST     = 4'd2,
    PE_CLRACC   = 4'd3,
    PE_CMP      = 4'd4,
    PE_RESTORE  = 4'd5,
    PE_REENABLE = 4'd6,
    PE_TSAVE    = 4'd7,
    PE_TGATE    = 4'd8,
    PE_LEARN    = 4'd9
  } pe_cmd_e;

endpackage

// File: rtl/pe_regfile.sv
module pe_regfile #(
  parameter int DW     = 10,
  parameter int NWORDS = 8,
  localparam int AW    = $clog2(NWORDS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);

  logic [DW-1:0] word_q [NWORDS];

  for (genvar g = 0; g < NWORDS; g++) begin : g_word
    logic          hit;
    logic [DW-1:0] word_d;

    always_comb begin
      hit    = we_i && (addr_i == AW'(g));
      word_d = hit ? wdata_i : word_q[g];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) word_q[g] <= '0;
      else         word_q[g] <= word_d;
    end
  end

  assign rdata_o = word_q[addr_i];

endmodule

// File: rtl/pe_datapath.sv
module pe_datapath #(
  parameter int DW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          dist_go_i,
  input  logic          clr_i,
  input  logic          tsave_go_i,
  input  logic [DW-1:0] opnd_i,
  input  logic [DW-1:0] bus_i,
  output logic [DW-1:0] acc_o,
  output logic [DW-1:0] tdist_o,
  output logic [DW-1:0] mag_o,
  output logic          sign_o
);

  logic [DW-1:0] diff;
  logic [DW-1:0] pipe_q, pipe_d;
  logic          sign_q, sign_d;
  logic          pv_q, pv_d;
  logic [DW-1:0] acc_q, acc_d;
  logic [DW-1:0] td_q, td_d;

  // stage 1: subtract and register
  always_comb begin
    diff   = opnd_i - bus_i;
    pipe_d = dist_go_i ? diff : pipe_q;
    sign_d = dist_go_i ? diff[DW-1] : sign_q;
    pv_d   = dist_go_i && !clr_i;
  end

  // stage 2: accumulate magnitude
  always_comb begin
    if (clr_i)        acc_d = '0;
    else if (pv_q)    acc_d = sign_q ? (acc_q - pipe_q) : (acc_q + pipe_q);
    else              acc_d = acc_q;
    td_d = tsave_go_i ? acc_q : td_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pipe_q <= '0;
      sign_q <= 1'b0;
      pv_q   <= 1'b0;
      acc_q  <= '0;
      td_q   <= '0;
    end else begin
      pipe_q <= pipe_d;
      sign_q <= sign_d;
      pv_q   <= pv_d;
      acc_q  <= acc_d;
      td_q   <= td_d;
    end
  end

  assign acc_o   = acc_q;
  assign tdist_o = td_q;
  assign sign_o  = sign_q;
  assign mag_o   = sign_q ? (DW'(0) - pipe_q) : pipe_q;

endmodule

// File: rtl/pe_enable.sv
module pe_enable
  import pe_pkg::*;
#(
  parameter int DW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  pe_cmd_e       cmd_i,
  input  logic [DW-1:0] acc_i,
  input  logic [DW-1:0] tdist_i,
  input  logic [DW-1:0] bus_i,
  output logic          en_o,
  output logic          status_o
);

  logic en_q, en_d;
  logic sv_q, sv_d;

  always_comb begin
    en_d = en_q;
    sv_d = sv_q;
    unique case (cmd_i)
      PE_CMP: begin
        sv_d = en_q;
        if (en_q && (acc_i > bus_i)) en_d = 1'b0;
      end
      PE_RESTORE:  en_d = sv_q;
      PE_REENABLE: begin
        en_d = 1'b1;
        sv_d = 1'b1;
      end
      PE_TGATE: if (en_q && (tdist_i > bus_i)) en_d = 1'b0;
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= 1'b1;
      sv_q <= 1'b1;
    end else begin
      en_q <= en_d;
      sv_q <= sv_d;
    end
  end

  assign en_o     = en_q;
  assign status_o = en_q && (cmd_i == PE_CMP) && (acc_i < bus_i);

endmodule

// File: rtl/pe_stepper.sv
module pe_stepper #(
  parameter int DW = 10
) (
  input  logic [DW-1:0] word_i,
  input  logic          up_i,
  output logic [DW-1:0] word_o
);

  localparam logic [DW-1:0] TOP = {1'b0, {(DW-1){1'b1}}};
  localparam logic [DW-1:0] BOT = {1'b1, {(DW-1){1'b0}}};

  always_comb begin
    if (up_i) word_o = (word_i == TOP) ? word_i : word_i + DW'(1);
    else      word_o = (word_i == BOT) ? word_i : word_i - DW'(1);
  end

endmodule

// File: rtl/neuron_pe.sv
module neuron_pe
  import pe_pkg::*;
#(
  parameter int DW     = 10,
  parameter int NWORDS = 8,
  localparam int AW    = $clog2(NWORDS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [3:0]    cmd_i,
  input  logic [AW-1:0] addr_i,
  input  logic          sel_acc_i,
  input  logic [DW-1:0] bus_i,
  output logic          status_o,
  output logic          en_o,
  output logic [DW-1:0] acc_o,
  output logic [DW-1:0] rdata_o
);

  logic [1:0]    rs_q;
  logic          rst_n;
  pe_cmd_e       cmd;
  logic          en;
  logic [DW-1:0] acc, tdist, mag, rword, stepped, opnd, wdata;
  logic          sign;
  logic          dist_go, clr, tsave_go, learn_go, we;

  // reset release synchronizer
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rs_q <= 2'b00;
    else         rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_n = rs_q[1];

  always_comb begin
    cmd      = pe_cmd_e'(cmd_i);
    opnd     = sel_acc_i ? acc : rword;
    dist_go  = en && (cmd == PE_DIST);
    clr      = (cmd == PE_CLRACC);
    tsave_go = en && (cmd == PE_TSAVE);
    learn_go = en && (cmd == PE_LEARN) && (mag > bus_i);
    we       = (en && (cmd == PE_WRITE)) || learn_go;
    wdata    = (cmd == PE_WRITE) ? bus_i : stepped;
  end

  pe_regfile #(.DW(DW), .NWORDS(NWORDS)) u_rf (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .we_i    (we),
    .addr_i  (addr_i),
    .wdata_i (wdata),
    .rdata_o (rword)
  );

  pe_datapath #(.DW(DW)) u_dp (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .dist_go_i  (dist_go),
    .clr_i      (clr),
    .tsave_go_i (tsave_go),
    .opnd_i     (opnd),
    .bus_i      (bus_i),
    .acc_o      (acc),
    .tdist_o    (tdist),
    .mag_o      (mag),
    .sign_o     (sign)
  );

  pe_enable #(.DW(DW)) u_en (
    .clk_i    (clk_i),
    .rst_ni   (rst_n),
    .cmd_i    (cmd),
    .acc_i    (acc),
    .tdist_i  (tdist),
    .bus_i    (bus_i),
    .en_o     (en),
    .status_o (status_o)
  );

  pe_stepper #(.DW(DW)) u_step (
    .word_i (rword),
    .up_i   (sign),
    .word_o (stepped)
  );

  assign en_o    = en;
  assign acc_o   = acc;
  assign rdata_o = rword;

endmodule

// File: rtl/pe_checker.sv
module pe_checker #(
  parameter int DW     = 10,
  parameter int NWORDS = 8,
  localparam int AW    = $clog2(NWORDS)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [3:0]    cmd_i,
  input logic [AW-1:0] addr_i,
  input logic          sel_acc_i,
  input logic [DW-1:0] bus_i,
  input logic          status_o,
  input logic          en_o,
  input logic [DW-1:0] acc_o,
  input logic [DW-1:0] rdata_o
);

  localparam logic [DW-1:0] TOP = {1'b0, {(DW-1){1'b1}}};
  localparam logic [DW-1:0] BOT = {1'b1, {(DW-1){1'b0}}};

  a_r5_clear_zeroes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == 4'd3) |=> (acc_o == '0));

  a_r6_far_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == 4'd4 && en_o && acc_o > bus_i) |=> !en_o);

  a_r6_status_means_near: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o |-> (acc_o < bus_i));

  a_r7_reenable_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == 4'd6) |=> en_o);

  a_r8_tgate_keeps_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == 4'd8 && !en_o) |=> !en_o);

  a_r10_no_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == 4'd9) |=> (!$stable(addr_i) ||
      !(($past(rdata_o) == TOP && rdata_o == BOT) ||
        ($past(rdata_o) == BOT && rdata_o == TOP))));

  a_r11_disabled_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_o |=> (!$stable(addr_i) || $stable(rdata_o)));

  a_r11_status_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_o |-> !status_o);

endmodule

bind neuron_pe pe_checker #(.DW(DW), .NWORDS(NWORDS)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cmd_i     (cmd_i),
  .addr_i    (addr_i),
  .sel_acc_i (sel_acc_i),
  .bus_i     (bus_i),
  .status_o  (status_o),
  .en_o      (en_o),
  .acc_o     (acc_o),
  .rdata_o   (rdata_o)
);

// File: tb/sim_neuron_pe.sv
`timescale 1ns/1ps
module sim_neuron_pe;

  localparam int NV = 52;

  typedef struct packed {
    logic [3:0] req;
    logic [3:0] cmd;
    logic [2:0] addr;
    logic       sel;
    logic [9:0] bus;
    logic       st;
    logic       en;
    logic [9:0] acc;
    logic [9:0] rd;
  } vec_t;

  function automatic vec_t mk(int req, int cmd, int addr, int sel, int bus,
                              int st, int en, int acc, int rd);
    vec_t v;
    v.req = req[3:0]; v.cmd = cmd[3:0]; v.addr = addr[2:0]; v.sel = sel[0];
    v.bus = bus[9:0]; v.st = st[0]; v.en = en[0]; v.acc = acc[9:0]; v.rd = rd[9:0];
    return v;
  endfunction

  // cmd: 0 nop 1 write 2 diff 3 clear 4 search 5 restore 6 re-enable 7 tsave 8 tgate 9 learn
  localparam vec_t VEC [NV] = '{
    mk(2, 1, 0, 0,   7, 0, 1,   0,    7),  // R2 write
    mk(2, 1, 1, 0,  -3, 0, 1,   0,   -3),  // R2
    mk(2, 1, 2, 0,  20, 0, 1,   0,   20),  // R2
    mk(3, 2, 0, 0,  10, 0, 1,   0,    7),  // R3 diff -3
    mk(3, 2, 1, 0,   2, 0, 1,   3,   -3),  // R3 acc +3, diff -5
    mk(3, 2, 2, 0,   5, 0, 1,   8,   20),  // R3 acc +5, diff 15
    mk(3, 0, 2, 0,   0, 0, 1,  23,   20),  // R3 acc +15
    mk(6, 4, 0, 0,  30, 1, 1,  23,    7),  // R6 below -> status
    mk(6, 4, 0, 0,  23, 0, 1,  23,    7),  // R6 equal keeps
    mk(6, 4, 0, 0,  10, 0, 0,  23,    7),  // R6 above drops
    mk(7, 5, 0, 0,   0, 0, 1,  23,    7),  // R7 restore
    mk(6, 4, 0, 0,  10, 0, 0,  23,    7),  // R6
    mk(11, 4, 0, 0, 50, 0, 0,  23,    7),  // R11 status low
    mk(7, 5, 0, 0,   0, 0, 0,  23,    7),  // R7 restore to off
    mk(11, 1, 0, 0, 99, 0, 0,  23,    7),  // R11 write ignored
    mk(11, 2, 0, 0,  0, 0, 0,  23,    7),  // R11 diff ignored
    mk(11, 0, 0, 0,  0, 0, 0,  23,    7),  // R11
    mk(5, 3, 0, 0,   0, 0, 0,   0,    7),  // R5 clear while off
    mk(7, 6, 0, 0,   0, 0, 1,   0,    7),  // R7 re-enable
    mk(4, 2, 0, 1,   4, 0, 1,   0,    7),  // R4 acc operand
    mk(4, 0, 0, 0,   0, 0, 1,   4,    7),  // R4
    mk(4, 2, 0, 1,   1, 0, 1,   4,    7),  // R4
    mk(4, 0, 0, 0,   0, 0, 1,   7,    7),  // R4
    mk(5, 2, 0, 0,   1, 0, 1,   7,    7),  // R5
    mk(5, 3, 0, 0,   0, 0, 1,   0,    7),  // R5 clear beats pending
    mk(5, 0, 0, 0,   0, 0, 1,   0,    7),  // R5
    mk(9, 2, 2, 0,  12, 0, 1,   0,   20),  // R9 diff +8
    mk(9, 9, 2, 0,   5, 0, 1,   8,   19),  // R9 step down
    mk(9, 9, 2, 0,   8, 0, 1,   8,   19),  // R9 equal no step
    mk(9, 2, 1, 0,   0, 0, 1,   8,   -3),  // R9 diff -3
    mk(9, 9, 1, 0,   1, 0, 1,  11,   -2),  // R9 step up
    mk(5, 3, 3, 0,   0, 0, 1,   0,    0),  // R5
    mk(2, 1, 3, 0,   4, 0, 1,   0,    4),  // R2
    mk(8, 2, 3, 0,   1, 0, 1,   0,    4),  // R8
    mk(8, 0, 3, 0,   0, 0, 1,   3,    4),  // R8
    mk(8, 7, 3, 0,   0, 0, 1,   3,    4),  // R8 save 3
    mk(8, 8, 3, 0,   3, 0, 1,   3,    4),  // R8 equal keeps
    mk(8, 8, 3, 0,   2, 0, 0,   3,    4),  // R8 above drops
    mk(7, 6, 3, 0,   0, 0, 1,   3,    4),  // R7
    mk(2, 1, 4, 0, 511, 0, 1,   3,  511),  // R2
    mk(10, 2, 4, 0, -512, 0, 1, 3,  511),  // R10 diff wraps to -1
    mk(10, 9, 4, 0,  0, 0, 1,   4,  511),  // R10 top holds
    mk(2, 1, 5, 0, -512, 0, 1,  4, -512),  // R2
    mk(10, 2, 5, 0,  5, 0, 1,   4, -512),  // R10 diff wraps to 507
    mk(10, 9, 5, 0,  0, 0, 1, 511, -512),  // R10 bottom holds
    mk(6, 4, 2, 0,   0, 0, 0, 511,   19),  // R6
    mk(11, 2, 2, 0, 100, 0, 0, 511,  19),  // R11
    mk(11, 9, 2, 0,  0, 0, 0, 511,   19),  // R11 learn ignored
    mk(11, 7, 2, 0,  0, 0, 0, 511,   19),  // R11 tsave ignored
    mk(7, 6, 2, 0,   0, 0, 1, 511,   19),  // R7
    mk(11, 8, 2, 0, 100, 0, 1, 511,  19),  // R11 distance still 3
    mk(6, 4, 2, 0, 600, 1, 1, 511,   19)   // R6 unsigned compare
  };

  logic       clk = 1'b0;
  logic       rst_ni;
  logic [3:0] cmd_i;
  logic [2:0] addr_i;
  logic       sel_acc_i;
  logic [9:0] bus_i;
  logic       status_o, en_o;
  logic [9:0] acc_o, rdata_o;
  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  neuron_pe u0 (
    .clk_i(clk), .rst_ni(rst_ni), .cmd_i(cmd_i), .addr_i(addr_i),
    .sel_acc_i(sel_acc_i), .bus_i(bus_i), .status_o(status_o),
    .en_o(en_o), .acc_o(acc_o), .rdata_o(rdata_o)
  );

  task automatic chk(int req, string what, logic [9:0] act, logic [9:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic reset_and_check();  // R1
    @(negedge clk);
    rst_ni = 1'b0; cmd_i = 4'd0; addr_i = 3'd0; sel_acc_i = 1'b0; bus_i = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    chk(1, "enable", {9'd0, en_o}, 10'd1);
    chk(1, "acc", acc_o, 10'd0);
    chk(1, "status", {9'd0, status_o}, 10'd0);
    for (int a = 0; a < 8; a++) begin
      addr_i = a[2:0];
      #1 chk(1, "word", rdata_o, 10'd0);
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual still running, expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_ni = 1'b0; cmd_i = 4'd0; addr_i = 3'd0; sel_acc_i = 1'b0; bus_i = '0;
    reset_and_check();
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      cmd_i = VEC[i].cmd; addr_i = VEC[i].addr;
      sel_acc_i = VEC[i].sel; bus_i = VEC[i].bus;
      #1 chk(int'(VEC[i].req), $sformatf("v%0d status", i), {9'd0, status_o}, {9'd0, VEC[i].st});
      @(posedge clk);
      #1;
      chk(int'(VEC[i].req), $sformatf("v%0d enable", i), {9'd0, en_o}, {9'd0, VEC[i].en});
      chk(int'(VEC[i].req), $sformatf("v%0d acc", i), acc_o, VEC[i].acc);
      chk(int'(VEC[i].req), $sformatf("v%0d word", i), rdata_o, VEC[i].rd);
    end
    @(negedge clk);
    cmd_i = 4'd0;
    // R1: reset in the middle of activity returns everything to its start values
    reset_and_check();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule